// File: doc/BRIEF.md
# Resource Fault Isolation Accumulator

This block narrows a single faulty resource down to one cell of a grid of `ROWS` by `COLS` resources. Several alternative configurations share the grid. Each configuration has a usage map with one bit per cell, and a set bit means that configuration occupies the cell. Once a configuration has been run, an outside comparator reports whether it disagreed with its competitor (discrepant) or agreed with it. The report names the configuration, and the block uses that outcome to shrink a set of suspect cells.

A discrepant report keeps only the suspects the configuration used. An agreeing report removes the cells it used, because those cells just produced correct results. At the same time, every discrepant report adds one to a saturating per-cell history counter for each cell in the reported map. This builds a long-term record of which cells take part in failures. When exactly one suspect is left, the block raises a done flag and presents that cell's row and column. If the set becomes empty, it raises an inconsistency flag instead, which points to more than one fault or to an intermittent one. Either result is frozen until a clear pulse starts a new round.

Usage maps are written through a simple one-cycle write port. A read port with a row and column address returns any history counter.

Top module: `fault_isolator`

## Requirements
- R1: After reset the suspect set has every bit set, every history counter reads 0, both flags are low, the result row and column read 0, and every stored usage map is all zeros.
- R2: With `map_we` high, `map_bits` is written into usage slot `map_sel` at the clock edge. Cell (r,c) is bit r*COLS+c. A report at the same edge that names the same slot uses the slot's previous contents.
- R3: A valid discrepant report adds one to the history counter of every cell whose bit is set in the named map. All other counters are unchanged. `hist_val` shows cell (`hist_row`,`hist_col`) combinationally.
- R4: History counters are HIST_W bits wide and hold at 2^HIST_W-1 instead of wrapping.
- R5: A valid discrepant report replaces the suspect set with its AND with the named map, visible on `suspect_map` after that edge.
- R6: A valid agreeing report replaces the suspect set with its AND with the complement of the named map, and it leaves all history counters unchanged.
- R7: When a report leaves exactly one suspect bit, `iso_done` goes high after that edge. `iso_row`/`iso_col` give that cell's row and column.
- R8: While `iso_done` or `inconsistent` is high, reports leave the suspect set, the flags and the row/column unchanged. Discrepant reports still update history.
- R9: When a report leaves the suspect set empty, `inconsistent` goes high after that edge and `iso_done` stays low.
- R10: A `clr` pulse sets the suspect set back to all ones, drops both flags and zeroes row/column. It discards any report at the same edge and leaves history and usage maps as they were.
- R11: With `rpt_valid` low, the suspect set, the flags and the history do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Starts a new isolation round |
| map_we | input | 1 | Usage map write strobe |
| map_sel | input | $clog2(NCFG) | Slot written by `map_we` |
| map_bits | input | ROWS*COLS | Usage map, cell (r,c) at bit r*COLS+c |
| rpt_valid | input | 1 | Report strobe |
| rpt_sel | input | $clog2(NCFG) | Configuration named in the report |
| rpt_disc | input | 1 | 1 = discrepant, 0 = agreed |
| hist_row | input | $clog2(ROWS) | History read row |
| hist_col | input | $clog2(COLS) | History read column |
| hist_val | output | HIST_W | History counter of the addressed cell |
| suspect_map | output | ROWS*COLS | Current suspect set |
| iso_done | output | 1 | Exactly one suspect remains |
| iso_row | output | $clog2(ROWS) | Row of the isolated cell |
| iso_col | output | $clog2(COLS) | Column of the isolated cell |
| inconsistent | output | 1 | Suspect set became empty |

## Verification
The bench runs a four-step narrowing sequence that mixes discrepant and agreeing reports and ends on cell (3,3). A design that used the wrong polarity for agreeing reports would keep the wrong half of the grid and never isolate that cell. It then sends reports after the result is reached. A block that did not freeze would go on shrinking the set and drop the reported location, and a block that also froze history would lose increments.

An agreeing report that empties the set must raise the inconsistency flag and not a false isolation. A clear arriving together with a report must win, and one that did not would show a shrunk set. A report that shares an edge with a rewrite of its own map must use the old map. The history counters are driven far past their maximum, so a wrapping counter would read near zero.

// File: rtl/fia_pkg.sv
package fia_pkg;
    // Default geometry and counter width used by the top level
    localparam int unsigned FIA_ROWS   = 8;
    localparam int unsigned FIA_COLS   = 8;
    localparam int unsigned FIA_NCFG   = 4;
    localparam int unsigned FIA_HIST_W = 8;

    // Width helper that never returns zero
    function automatic int unsigned fia_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/fia_map_store.sv
module fia_map_store #(
    parameter int unsigned NCFG  = 4,
    parameter int unsigned CELLS = 64,
    localparam int unsigned SEL_W = fia_pkg::fia_w(NCFG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CELLS-1:0] wr_bits,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CELLS-1:0] rd_bits
);
    logic [CELLS-1:0] maps_d [NCFG];
    logic [CELLS-1:0] maps_q [NCFG];

    always_comb begin
        maps_d = maps_q;
        if (wr_en && (int'(wr_sel) < int'(NCFG))) begin
            maps_d[wr_sel] = wr_bits;
        end
        rd_bits = (int'(rd_sel) < int'(NCFG)) ? maps_q[rd_sel] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NCFG); i++) begin
                maps_q[i] <= '0;
            end
        end else begin
            maps_q <= maps_d;
        end
    end
endmodule

// File: rtl/fia_hist_bank.sv
module fia_hist_bank #(
    parameter int unsigned CELLS = 64,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned IDX_W = fia_pkg::fia_w(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [CELLS-1:0] inc_mask,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_ok,
    output logic [CNT_W-1:0] rd_val
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_d [CELLS];
    logic [CNT_W-1:0] cnt_q [CELLS];

    // One saturating incrementer per cell
    for (genvar g = 0; g < int'(CELLS); g++) begin : g_cell
        assign cnt_d[g] = (inc_en && inc_mask[g] && (cnt_q[g] != SAT))
                          ? cnt_q[g] + CNT_W'(1) : cnt_q[g];
    end

    always_comb begin
        rd_val = rd_ok ? cnt_q[rd_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(CELLS); i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fia_suspect.sv
module fia_suspect #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    localparam int unsigned CELLS = ROWS * COLS,
    localparam int unsigned RW    = fia_pkg::fia_w(ROWS),
    localparam int unsigned CW    = fia_pkg::fia_w(COLS),
    localparam int unsigned IDX_W = fia_pkg::fia_w(CELLS),
    localparam int unsigned POP_W = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             disc,
    input  logic [CELLS-1:0] map,
    output logic [CELLS-1:0] sus,
    output logic             done,
    output logic             incons,
    output logic [RW-1:0]    row,
    output logic [CW-1:0]    col
);
    typedef struct packed {
        logic [CELLS-1:0] sus;
        logic             done;
        logic             incons;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
    } trk_t;

    localparam trk_t FRESH = '{sus: '1, done: 1'b0, incons: 1'b0, row: '0, col: '0};

    trk_t             st_d, st_q;
    logic [CELLS-1:0] cand;
    logic [POP_W-1:0] pop;
    logic [IDX_W-1:0] hit;

    always_comb begin
        cand = disc ? (st_q.sus & map) : (st_q.sus & ~map);
        pop  = '0;
        hit  = '0;
        for (int i = 0; i < int'(CELLS); i++) begin
            pop = pop + POP_W'(cand[i]);
            if (cand[i]) begin
                hit = IDX_W'(i);
            end
        end

        st_d = st_q;
        if (clr) begin
            st_d = FRESH;
        end else if (upd && !st_q.done && !st_q.incons) begin
            st_d.sus = cand;
            if (pop == '0) begin
                st_d.incons = 1'b1;
            end else if (pop == POP_W'(1)) begin
                st_d.done = 1'b1;
                st_d.row  = RW'(int'(hit) / int'(COLS));
                st_d.col  = CW'(int'(hit) % int'(COLS));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FRESH;
        end else begin
            st_q <= st_d;
        end
    end

    assign sus    = st_q.sus;
    assign done   = st_q.done;
    assign incons = st_q.incons;
    assign row    = st_q.row;
    assign col    = st_q.col;
endmodule

// File: rtl/fault_isolator.sv
module fault_isolator #(
    parameter int unsigned ROWS   = fia_pkg::FIA_ROWS,
    parameter int unsigned COLS   = fia_pkg::FIA_COLS,
    parameter int unsigned NCFG   = fia_pkg::FIA_NCFG,
    parameter int unsigned HIST_W = fia_pkg::FIA_HIST_W,
    localparam int unsigned CELLS = ROWS * COLS,
    localparam int unsigned RW    = fia_pkg::fia_w(ROWS),
    localparam int unsigned CW    = fia_pkg::fia_w(COLS),
    localparam int unsigned SEL_W = fia_pkg::fia_w(NCFG),
    localparam int unsigned IDX_W = fia_pkg::fia_w(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              map_we,
    input  logic [SEL_W-1:0]  map_sel,
    input  logic [CELLS-1:0]  map_bits,
    input  logic              rpt_valid,
    input  logic [SEL_W-1:0]  rpt_sel,
    input  logic              rpt_disc,
    input  logic [RW-1:0]     hist_row,
    input  logic [CW-1:0]     hist_col,
    output logic [HIST_W-1:0] hist_val,
    output logic [CELLS-1:0]  suspect_map,
    output logic              iso_done,
    output logic [RW-1:0]     iso_row,
    output logic [CW-1:0]     iso_col,
    output logic              inconsistent
);
    logic [CELLS-1:0] cur_map;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_ok;
    logic             take;

    // A report counts only when no clear shares its edge
    assign take   = rpt_valid && !clr;
    assign rd_ok  = (int'(hist_row) < int'(ROWS)) && (int'(hist_col) < int'(COLS));
    assign rd_idx = IDX_W'(int'(hist_row) * int'(COLS) + int'(hist_col));

    fia_map_store #(.NCFG(NCFG), .CELLS(CELLS)) u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_sel  (map_sel),
        .wr_bits (map_bits),
        .rd_sel  (rpt_sel),
        .rd_bits (cur_map)
    );

    fia_hist_bank #(.CELLS(CELLS), .CNT_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (take && rpt_disc),
        .inc_mask (cur_map),
        .rd_idx   (rd_idx),
        .rd_ok    (rd_ok),
        .rd_val   (hist_val)
    );

    fia_suspect #(.ROWS(ROWS), .COLS(COLS)) u_sus (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .upd    (take),
        .disc   (rpt_disc),
        .map    (cur_map),
        .sus    (suspect_map),
        .done   (iso_done),
        .incons (inconsistent),
        .row    (iso_row),
        .col    (iso_col)
    );
endmodule

// File: rtl/fia_checker.sv
module fia_checker #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned COLS   = 8,
    parameter int unsigned HIST_W = 8,
    localparam int unsigned CELLS = ROWS * COLS,
    localparam int unsigned RW    = fia_pkg::fia_w(ROWS),
    localparam int unsigned CW    = fia_pkg::fia_w(COLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              rpt_valid,
    input logic [RW-1:0]     hist_row,
    input logic [CW-1:0]     hist_col,
    input logic [HIST_W-1:0] hist_val,
    input logic [CELLS-1:0]  suspect_map,
    input logic              iso_done,
    input logic [RW-1:0]     iso_row,
    input logic [CW-1:0]     iso_col,
    input logic              inconsistent
);
    localparam logic [HIST_W-1:0] HMAX = '1;

    assert_hist_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!$stable(hist_row) || !$stable(hist_col) ||
                  hist_val == $past(hist_val) ||
                  (HIST_W+1)'(hist_val) == (HIST_W+1)'($past(hist_val)) + (HIST_W+1)'(1)));

    assert_hist_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_val == HMAX) |=> (!$stable(hist_row) || !$stable(hist_col) || hist_val == HMAX));

    assert_only_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((suspect_map & ~$past(suspect_map)) == '0));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_done |-> ($countones(suspect_map) == 1));

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_done && !clr) |=> (iso_done && $stable(iso_row) && $stable(iso_col) && $stable(suspect_map)));

    assert_empty_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inconsistent |-> (suspect_map == '0 && !iso_done));

    assert_clear_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (suspect_map == '1 && !iso_done && !inconsistent));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_valid && !clr) |=> $stable(suspect_map));
endmodule

bind fault_isolator fia_checker #(.ROWS(ROWS), .COLS(COLS), .HIST_W(HIST_W)) u_fia_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .rpt_valid    (rpt_valid),
    .hist_row     (hist_row),
    .hist_col     (hist_col),
    .hist_val     (hist_val),
    .suspect_map  (suspect_map),
    .iso_done     (iso_done),
    .iso_row      (iso_row),
    .iso_col      (iso_col),
    .inconsistent (inconsistent)
);

// File: tb/test_fault_isolator.sv
`timescale 1ns/1ps
module test_fault_isolator;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int NCFG = 4;
    localparam int CELLS = ROWS * COLS;
    localparam int HMAX = 255;

    // Entry: [5]valid [4]disc [3:2]cfg [1]expected done [0]expected inconsistent
    localparam int NSTEP = 7;
    localparam logic [5:0] STEPS [NSTEP] = '{
        6'b110000, 6'b010100, 6'b110100, 6'b101000,
        6'b111110, 6'b110010, 6'b101010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic map_we = 1'b0;
    logic [1:0] map_sel = '0;
    logic [CELLS-1:0] map_bits = '0;
    logic rpt_valid = 1'b0;
    logic [1:0] rpt_sel = '0;
    logic rpt_disc = 1'b0;
    logic [2:0] hist_row = '0;
    logic [2:0] hist_col = '0;
    logic [7:0] hist_val;
    logic [CELLS-1:0] suspect_map;
    logic iso_done;
    logic [2:0] iso_row;
    logic [2:0] iso_col;
    logic inconsistent;

    int n_chk = 0;
    int n_bad = 0;

    logic [CELLS-1:0] m_map [NCFG];
    int               m_hist [CELLS];
    logic [CELLS-1:0] m_sus;
    logic             m_done, m_inc;
    int               m_row, m_col;

    always #5 clk = ~clk;

    fault_isolator i_fault_isolator (
        .clk(clk), .rst_n(rst_n), .clr(clr), .map_we(map_we), .map_sel(map_sel),
        .map_bits(map_bits), .rpt_valid(rpt_valid), .rpt_sel(rpt_sel), .rpt_disc(rpt_disc),
        .hist_row(hist_row), .hist_col(hist_col), .hist_val(hist_val),
        .suspect_map(suspect_map), .iso_done(iso_done), .iso_row(iso_row),
        .iso_col(iso_col), .inconsistent(inconsistent)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string step_tag(input int i);
        case (i)
            1: return "R11";
            3: return "R6";
            4: return "R7";
            5, 6: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic model_step(input bit c, input bit v, input bit d, input int s,
                              input bit we, input int ws, input logic [CELLS-1:0] wb);
        logic [CELLS-1:0] nx;
        if (c) begin
            m_sus = '1; m_done = 0; m_inc = 0; m_row = 0; m_col = 0;
        end else if (v) begin
            if (d) begin
                for (int i = 0; i < CELLS; i++)
                    if (m_map[s][i] && m_hist[i] < HMAX) m_hist[i]++;
            end
            if (!m_done && !m_inc) begin
                nx = d ? (m_sus & m_map[s]) : (m_sus & ~m_map[s]);
                m_sus = nx;
                if (nx == '0) m_inc = 1;
                else if ($countones(nx) == 1) begin
                    m_done = 1;
                    for (int i = 0; i < CELLS; i++)
                        if (nx[i]) begin m_row = i / COLS; m_col = i % COLS; end
                end
            end
        end
        if (we) m_map[ws] = wb;
    endtask

    task automatic step(input bit c, input bit v, input bit d, input int s,
                        input bit we, input int ws, input logic [CELLS-1:0] wb);
        @(negedge clk);
        clr = c; rpt_valid = v; rpt_disc = d; rpt_sel = 2'(s);
        map_we = we; map_sel = 2'(ws); map_bits = wb;
        @(posedge clk);
        #1;
        clr = 0; rpt_valid = 0; map_we = 0;
        model_step(c, v, d, s, we, ws, wb);
    endtask

    task automatic check_state(input string req);
        chk(suspect_map == m_sus, req, "suspect_map", suspect_map, m_sus);
        chk(iso_done == m_done, req, "iso_done", CELLS'(iso_done), CELLS'(m_done));
        chk(inconsistent == m_inc, req, "inconsistent", CELLS'(inconsistent), CELLS'(m_inc));
        chk(int'(iso_row) == m_row && int'(iso_col) == m_col, req, "row/col",
            CELLS'({iso_row, iso_col}), CELLS'({3'(m_row), 3'(m_col)}));
    endtask

    task automatic check_hist(input string req);
        bit ok = 1;
        int bad_i = 0;
        int bad_v = 0;
        for (int i = 0; i < CELLS; i++) begin
            hist_row = 3'(i / COLS); hist_col = 3'(i % COLS);
            #0.1;
            if (ok && int'(hist_val) != m_hist[i]) begin ok = 0; bad_i = i; bad_v = int'(hist_val); end
        end
        chk(ok, req, $sformatf("history cell %0d", bad_i), CELLS'(bad_v), CELLS'(m_hist[bad_i]));
    endtask

    task automatic load_map(input int s, input logic [CELLS-1:0] b);
        step(0, 0, 0, 0, 1, s, b);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCFG; i++) m_map[i] = '0;
        for (int i = 0; i < CELLS; i++) m_hist[i] = 0;
        m_sus = '1; m_done = 0; m_inc = 0; m_row = 0; m_col = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #2;
        // R1: reset state
        check_state("R1");
        check_hist("R1");
        // R1: maps are zero after reset, so a discrepant report empties the set
        step(0, 1, 1, 2, 0, 0, '0);
        check_state("R1");
        step(1, 0, 0, 0, 0, 0, '0);

        // R2: load usage maps; cell (r,c) is bit r*8+c
        load_map(0, 64'h0000_0000_FFFF_FFFF);   // rows 0-3
        load_map(1, 64'h0F0F_0F0F_0F0F_0F0F);   // columns 0-3
        load_map(2, 64'h0000_0000_00FF_FFFF);   // rows 0-2
        load_map(3, 64'h2828_2828_2828_2828);   // columns 3 and 5

        // Table walk: narrows to cell (3,3), then reports after the result
        for (int i = 0; i < NSTEP; i++) begin
            step(1'b0, STEPS[i][5], STEPS[i][4], int'(STEPS[i][3:2]), 0, 0, '0);
            check_state(step_tag(i));
            chk(iso_done == STEPS[i][1] && inconsistent == STEPS[i][0], step_tag(i),
                "table flags", CELLS'({iso_done, inconsistent}), CELLS'(STEPS[i][1:0]));
        end
        chk(iso_row == 3'd3 && iso_col == 3'd3, "R7", "isolated cell",
            CELLS'({iso_row, iso_col}), CELLS'({3'd3, 3'd3}));
        check_hist("R3");

        // R10: clear wins over a report at the same edge; history kept
        step(1, 1, 1, 0, 0, 0, '0);
        check_state("R10");
        check_hist("R10");

        // R9: empty suspect set raises inconsistent
        step(0, 1, 1, 2, 0, 0, '0);
        check_state("R5");
        step(0, 1, 0, 2, 0, 0, '0);
        check_state("R9");
        chk(inconsistent && !iso_done, "R9", "flags", CELLS'({iso_done, inconsistent}), CELLS'(2'b01));
        step(0, 1, 1, 1, 0, 0, '0);
        check_state("R8");
        check_hist("R8");
        step(1, 0, 0, 0, 0, 0, '0);
        check_state("R10");

        // R6: agreeing report leaves history alone
        step(0, 1, 0, 1, 0, 0, '0);
        check_state("R6");
        check_hist("R6");
        step(1, 0, 0, 0, 0, 0, '0);

        // R2: rewrite slot 0 while reporting it; old map applies
        step(0, 1, 1, 0, 1, 0, 64'hFF00_0000_0000_0000);
        check_state("R2");
        chk(suspect_map == 64'h0000_0000_FFFF_FFFF, "R2", "old map used",
            suspect_map, 64'h0000_0000_FFFF_FFFF);
        step(1, 0, 0, 0, 0, 0, '0);
        step(0, 1, 1, 0, 0, 0, '0);
        chk(suspect_map == 64'hFF00_0000_0000_0000, "R2", "new map used",
            suspect_map, 64'hFF00_0000_0000_0000);

        // R4: drive counters past saturation
        step(1, 0, 0, 0, 0, 0, '0);
        for (int k = 0; k < 260; k++) step(0, 1, 1, 3, 0, 0, '0);
        check_hist("R4");
        hist_row = 3'd0; hist_col = 3'd3;
        #0.1;
        chk(hist_val == 8'd255, "R4", "cell (0,3) saturated", CELLS'(hist_val), CELLS'(255));
        check_state("R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule